// File: doc/BRIEF.md
# Compare-and-Branch Resolver

This block decides conditional branches for a small 32-bit processor that keeps no condition flags. A compare instruction instead saves two general-register values into a pair of internal operand registers, the left and the right operand. A later 16-bit branch instruction names one of ten relations between those two saved values. It also carries a short signed displacement relative to the PC.

The decode stage presents the branch halfword, a valid strobe and the address of that branch. One cycle later the block reports the following on its result ports:
- whether the branch is taken;
- the address to continue from;
- or, for an unassigned relation code, an illegal-instruction request that carries the branch's own address.

Fetch, the register file and any flush or pipeline control belong to neighbouring blocks.

Top module: `branch_resolve`

## Requirements
- R1: While `rst_n` is low, and after it is released, `res_valid`, `res_taken` and `res_illegal` are 0, `res_pc` is 0 and both saved operands are 0. A first "equal" branch with no compare before it is therefore taken.
- R2: When `cmp_valid` is high at a clock edge, `cmp_lhs` is saved as the left operand and `cmp_rhs` as the right operand. Every later branch tests these saved values until the next compare.
- R3: Relation codes in opcode bits 13:10 are defined as follows, all evaluated left against right. Codes 0 and 1 are equal and not-equal. The two's-complement relations are: 2 less-than, 3 greater-than, 6 greater-or-equal, 7 less-or-equal.
- R4: The unsigned relation codes are: 4 less-than, 5 greater-than, 8 greater-or-equal, 9 less-or-equal.
- R5: When the relation holds, `res_taken` is 1 and `res_pc` is branch PC + 2 + displacement. The displacement is opcode bits 9:0 sign-extended from bit 9 and multiplied by two, so it spans -1024 to +1022.
- R6: When the relation does not hold, `res_taken` is 0 and `res_pc` is branch PC + 2.
- R7: Relation codes 0xA to 0xF give `res_illegal` = 1 with `res_valid` = 0 and `res_taken` = 0. In that case `res_pc` is the branch's own address.
- R8: When a compare and a branch arrive in the same cycle, the branch tests the operand values saved before that compare. The new values apply from the next branch on.
- R9: Each accepted branch gives exactly one one-cycle pulse on `res_valid` or `res_illegal`, in the cycle after its strobe. With no strobe, neither pulse appears.
- R10: A strobe whose opcode bits 15:14 are not 2'b11 is not a branch. It produces neither `res_valid` nor `res_illegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_valid | input | 1 | Compare instruction strobe |
| cmp_lhs | input | 32 | Value saved as the left operand |
| cmp_rhs | input | 32 | Value saved as the right operand |
| br_valid | input | 1 | Branch instruction strobe |
| br_opcode | input | 16 | Branch halfword |
| br_pc | input | 32 | Address of the branch |
| res_valid | output | 1 | Resolved branch pulse |
| res_taken | output | 1 | Branch taken, qualified by res_valid |
| res_illegal | output | 1 | Illegal-instruction request pulse |
| res_pc | output | 32 | Next PC, or the faulting PC when res_illegal is high |

## Verification
The only state in the block is the pair of saved operands and the result register. A stale or corrupt operand shows up at the first branch after it: that branch gives the wrong taken decision and the wrong `res_pc`, one cycle after the branch strobe. For that reason each compare in the bench is followed at once by branches whose relations split on the sign bit and on equality. A result register holding stale data would leave `res_valid` or `res_illegal` high in an idle cycle, or give a pulse one cycle late, and the bench samples exactly one cycle after each strobe to catch both.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int XLEN = 32,
  parameter int OFFW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_valid,
  input  logic [XLEN-1:0]     cmp_lhs,
  input  logic [XLEN-1:0]     cmp_rhs,
  input  logic                br_valid,
  input  logic [OFFW+5:0]     br_opcode,
  input  logic [XLEN-1:0]     br_pc,
  output logic                res_valid,
  output logic                res_taken,
  output logic                res_illegal,
  output logic [XLEN-1:0]     res_pc
);
  localparam int ILEN = OFFW + 6;
  localparam int SEL_LO = OFFW;
  localparam int SEL_HI = OFFW + 3;
  localparam logic [XLEN-1:0] STEP = XLEN'(2);

  logic [XLEN-1:0] opa, opb;
  logic [3:0]      sel;
  logic            is_br, hit, known;
  logic [XLEN-1:0] disp, seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa <= '0;
      opb <= '0;
    end else if (cmp_valid) begin
      opa <= cmp_lhs;
      opb <= cmp_rhs;
    end
  end

  assign is_br  = br_valid && (br_opcode[ILEN-1 -: 2] == 2'b11);
  assign sel    = br_opcode[SEL_HI:SEL_LO];
  assign disp   = {{(XLEN-OFFW-1){br_opcode[OFFW-1]}}, br_opcode[OFFW-1:0], 1'b0};
  assign seq_pc = br_pc + STEP;

  always_comb begin
    known = 1'b1;
    hit   = 1'b0;
    case (sel)
      4'h0: hit = (opa == opb);
      4'h1: hit = (opa != opb);
      4'h2: hit = ($signed(opa) <  $signed(opb));
      4'h3: hit = ($signed(opa) >  $signed(opb));
      4'h4: hit = (opa <  opb);
      4'h5: hit = (opa >  opb);
      4'h6: hit = ($signed(opa) >= $signed(opb));
      4'h7: hit = ($signed(opa) <= $signed(opb));
      4'h8: hit = (opa >= opb);
      4'h9: hit = (opa <= opb);
      default: known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      res_illegal <= 1'b0;
      res_pc      <= '0;
    end else begin
      res_valid   <= is_br && known;
      res_taken   <= is_br && known && hit;
      res_illegal <= is_br && !known;
      if (is_br) begin
        if (!known)   res_pc <= br_pc;
        else if (hit) res_pc <= seq_pc + disp;
        else          res_pc <= seq_pc;
      end
    end
  end
endmodule

module branch_resolve_chk #(
  parameter int XLEN = 32,
  parameter int OFFW = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            br_valid,
  input logic [OFFW+5:0] br_opcode,
  input logic [XLEN-1:0] br_pc,
  input logic            res_valid,
  input logic            res_taken,
  input logic            res_illegal,
  input logic [XLEN-1:0] res_pc
);
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_valid, res_illegal}));
  assert_pulse_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || res_illegal) |-> $past(br_valid));
  assert_branch_class_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || res_illegal) |-> ($past(br_opcode[OFFW+5:OFFW+4]) == 2'b11));
  assert_fault_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> (res_pc == $past(br_pc) && !res_taken));
  assert_fallthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken) |-> (res_pc == $past(br_pc) + XLEN'(2)));
  assert_taken_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_taken |-> res_valid);
endmodule

bind branch_resolve branch_resolve_chk #(.XLEN(XLEN), .OFFW(OFFW)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_opcode(br_opcode),
  .br_pc(br_pc), .res_valid(res_valid), .res_taken(res_taken),
  .res_illegal(res_illegal), .res_pc(res_pc));

// File: tb/test_branch_resolve.sv
module test_branch_resolve;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_lhs = '0, cmp_rhs = '0;
  logic        br_valid = 1'b0;
  logic [15:0] br_opcode = '0;
  logic [31:0] br_pc = '0;
  logic        res_valid, res_taken, res_illegal;
  logic [31:0] res_pc;

  int n_chk = 0;
  int n_bad = 0;

  branch_resolve i_branch_resolve (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_lhs(cmp_lhs),
    .cmp_rhs(cmp_rhs), .br_valid(br_valid), .br_opcode(br_opcode),
    .br_pc(br_pc), .res_valid(res_valid), .res_taken(res_taken),
    .res_illegal(res_illegal), .res_pc(res_pc));

  always #2.5 clk = ~clk;

  // {lhs, rhs, relation, offset10, pc, taken}
  localparam int NV = 15;
  localparam logic [110:0] VEC [NV] = '{
    {32'h0000_0005, 32'h0000_0005, 4'h0, 10'h010, 32'h0000_1000, 1'b1},
    {32'h0000_0005, 32'h0000_0006, 4'h0, 10'h010, 32'h0000_1000, 1'b0},
    {32'h0000_0005, 32'h0000_0006, 4'h1, 10'h1FF, 32'h0000_2000, 1'b1},
    {32'hFFFF_FFFF, 32'h0000_0001, 4'h2, 10'h200, 32'h0000_3000, 1'b1},
    {32'hFFFF_FFFF, 32'h0000_0001, 4'h4, 10'h200, 32'h0000_3000, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0001, 4'h3, 10'h3FF, 32'h0000_3010, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0001, 4'h5, 10'h3FF, 32'h0000_3010, 1'b1},
    {32'h0000_0003, 32'h0000_0003, 4'h6, 10'h004, 32'h0000_0100, 1'b1},
    {32'h0000_0003, 32'h0000_0003, 4'h7, 10'h3F0, 32'h0000_0100, 1'b1},
    {32'h0000_0002, 32'h0000_0003, 4'h8, 10'h008, 32'h0000_0200, 1'b0},
    {32'h0000_0002, 32'h0000_0003, 4'h9, 10'h008, 32'h0000_0200, 1'b1},
    {32'h8000_0000, 32'h7FFF_FFFF, 4'h7, 10'h020, 32'h0001_0000, 1'b1},
    {32'h8000_0000, 32'h7FFF_FFFF, 4'h8, 10'h020, 32'h0001_0000, 1'b1},
    {32'h0000_0007, 32'h0000_0002, 4'h3, 10'h100, 32'h0000_4000, 1'b1},
    {32'h0000_0007, 32'h0000_0002, 4'h2, 10'h100, 32'h0000_4000, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_lhs = a; cmp_rhs = b;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  // drive a branch for one cycle, sample the registered result one cycle later
  task automatic branch(input logic [15:0] op, input logic [31:0] pc);
    br_valid = 1'b1; br_opcode = op; br_pc = pc;
    @(negedge clk);
    br_valid = 1'b0; cmp_valid = 1'b0;
  endtask

  function automatic logic [31:0] target(input logic [9:0] off, input logic [31:0] pc);
    logic [31:0] d;
    d = {{22{off[9]}}, off} * 32'd2;
    return pc + 32'd2 + d;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", {31'b0, res_valid}, 32'd0);
    check("R1 taken", {31'b0, res_taken}, 32'd0);
    check("R1 illegal", {31'b0, res_illegal}, 32'd0);
    check("R1 pc", res_pc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: operands reset to zero so equal is taken
    branch(16'hC000 | 16'h004, 32'h0000_0800);
    check("R1 zero operands taken", {31'b0, res_taken}, 32'd1);
    check("R1 zero operands pc", res_pc, 32'h0000_080A);

    // R2 R3 R4 R5 R6: table walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] a, b, pc, exp_pc;
      logic [3:0]  rel;
      logic [9:0]  off;
      logic        tk;
      {a, b, rel, off, pc, tk} = VEC[i];
      compare(a, b);
      branch({2'b11, rel, off}, pc);
      exp_pc = tk ? target(off, pc) : pc + 32'd2;
      check($sformatf("R3/R4 vec%0d valid", i), {31'b0, res_valid}, 32'd1);
      check($sformatf("R3/R4 vec%0d taken", i), {31'b0, res_taken}, {31'b0, tk});
      check(tk ? $sformatf("R5 vec%0d pc", i) : $sformatf("R6 vec%0d pc", i), res_pc, exp_pc);
    end

    // R9: idle cycle gives no pulse
    @(negedge clk);
    check("R9 idle valid", {31'b0, res_valid}, 32'd0);
    check("R9 idle illegal", {31'b0, res_illegal}, 32'd0);

    // R8: same-cycle compare uses previous operands
    compare(32'd1, 32'd2);
    cmp_valid = 1'b1; cmp_lhs = 32'd9; cmp_rhs = 32'd9;
    branch(16'hC000, 32'h0000_5000);
    check("R8 old operands taken", {31'b0, res_taken}, 32'd0);
    check("R8 old operands pc", res_pc, 32'h0000_5002);
    branch(16'hC000, 32'h0000_5000);
    check("R8 new operands taken", {31'b0, res_taken}, 32'd1);
    check("R2 new operands pc", res_pc, 32'h0000_5002);

    // R7: unassigned relations
    branch({2'b11, 4'hA, 10'h010}, 32'h0000_6000);
    check("R7 code A illegal", {31'b0, res_illegal}, 32'd1);
    check("R7 code A valid", {31'b0, res_valid}, 32'd0);
    check("R7 code A pc", res_pc, 32'h0000_6000);
    branch({2'b11, 4'hF, 10'h3FF}, 32'h0000_7004);
    check("R7 code F illegal", {31'b0, res_illegal}, 32'd1);
    check("R7 code F taken", {31'b0, res_taken}, 32'd0);
    check("R7 code F pc", res_pc, 32'h0000_7004);
    @(negedge clk);
    check("R9 illegal single pulse", {31'b0, res_illegal}, 32'd0);

    // R10: non-branch class ignored
    branch({2'b10, 4'h0, 10'h010}, 32'h0000_8000);
    check("R10 valid", {31'b0, res_valid}, 32'd0);
    check("R10 illegal", {31'b0, res_illegal}, 32'd0);
    check("R10 pc held", res_pc, 32'h0000_7004);
    branch({2'b01, 4'hB, 10'h010}, 32'h0000_8000);
    check("R10 illegal code ignored", {31'b0, res_illegal}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule